// File: doc/BRIEF.md
# Indexed Configuration Register Port with Write Lock

This block is a bank of 256 eight-bit configuration registers that a host reaches through two I/O addresses on a simple ISA-style bus. One address holds a pointer that picks a register. The other address is a data window onto the register that the pointer picks. To read a register, the host first writes its number to the pointer address and then reads the window. To write a register, the host loads the pointer and then writes the window.

All writes through the window are refused while the bank is locked. The one exception is the guard register. Software opens the bank by storing a magic byte into the guard register. It may then perform as many pointer/window write pairs as it needs, and it closes the bank again by storing zero into the guard register. One bit of one control register does not hold a value. Writing a one to that bit sends a single-cycle request for a software management interrupt.

Top module: `cfg_index_port`

## Requirements
- R1: After synchronous reset the bank is locked, the pointer holds 00h, every configuration register holds 00h and `swi_req` is low.
- R2: A bus write to address 0022h loads the pointer with the write data on that clock edge. A bus read of 0022h returns the current pointer on `io_rdata` in the same cycle.
- R3: A bus read of address 0023h returns, in the same cycle, the register that the pointer selects. Reads are allowed whether the bank is locked or not.
- R4: While the bank is locked, a bus write to 0023h with any pointer value other than 13h changes no register and raises no interrupt request.
- R5: A write of C5h to 0023h while the pointer is 13h unlocks the bank. While the bank is unlocked, every write to 0023h stores its data into the selected register, for any number of successive pointer/data pairs.
- R6: A write of 00h to 0023h while the pointer is 13h locks the bank. Any other value written there, apart from C5h, leaves the lock state as it was.
- R7: Reading register 13h returns 01h while the bank is unlocked and 00h while it is locked. Register 13h stores no other data.
- R8: The pointer keeps its value across window accesses, so repeated reads or writes of 0023h all reach the same register.
- R9: An unlocked write to register 56h with data bit 6 set drives `swi_req` high for exactly the one cycle after that write edge. Bit 6 of register 56h always reads 0, and the other seven bits are stored as written.
- R10: Bus accesses to any address other than 0022h and 0023h change no state, and `io_rdata` is 00h whenever no read of those two addresses is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current bus access |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, valid in the cycle the read strobe is asserted |
| swi_req | output | 1 | One-cycle software management interrupt request |

## Verification
The bench attacks the guard register in three ways. It writes to other registers while the bank is locked, where a design that leaks these writes would show the new values on read-back. It writes stray values to the guard register, where a design that treats any nonzero byte as an unlock, or any non-magic byte as a relock, would flip state that should hold. It relocks the bank and then retries the interrupt bit, where a design that forgets the lock on that path would fire a spurious request. It also checks register 56h, where a design that stored bit 6 would read back 1 or hold the request high for more than one cycle. Finally it checks that the pointer persists and that stray addresses do nothing, where a design that cleared the pointer after a window access, or decoded only the low address bits, would return data from the wrong register.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int NREGS    = 1 << DATA_W;

    localparam logic [ADDR_W-1:0] PTR_PORT  = 16'h0022;
    localparam logic [ADDR_W-1:0] WIN_PORT  = 16'h0023;

    localparam logic [DATA_W-1:0] GUARD_IDX  = 8'h13;
    localparam logic [DATA_W-1:0] OPEN_KEY   = 8'hC5;
    localparam logic [DATA_W-1:0] CLOSE_KEY  = 8'h00;
    localparam logic [DATA_W-1:0] SWI_IDX    = 8'h56;
    localparam int                SWI_BIT    = 6;
    localparam logic [DATA_W-1:0] RESET_VAL  = 8'h00;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PTR_WR,
        OP_PTR_RD,
        OP_WIN_WR,
        OP_WIN_RD
    } bus_op_e;

    typedef struct packed {
        bus_op_e           op;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    // Value a write leaves in the register it targets (self-clearing bits dropped)
    function automatic logic [DATA_W-1:0] stored_value(
        input logic [DATA_W-1:0] idx,
        input logic [DATA_W-1:0] wdata
    );
        logic [DATA_W-1:0] v;
        v = wdata;
        if (idx == SWI_IDX) v[SWI_BIT] = 1'b0;
        return v;
    endfunction

    function automatic logic is_swi_fire(
        input logic [DATA_W-1:0] idx,
        input logic [DATA_W-1:0] wdata
    );
        return (idx == SWI_IDX) && wdata[SWI_BIT];
    endfunction

endpackage

// File: rtl/cfg_bus_decode.sv
module cfg_bus_decode
    import cfg_port_pkg::*;
#(
    parameter logic [ADDR_W-1:0] P_PTR = PTR_PORT,
    parameter logic [ADDR_W-1:0] P_WIN = WIN_PORT
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output bus_req_t          req_o
);
    logic hit_ptr;
    logic hit_win;

    assign hit_ptr = (addr_i == P_PTR);
    assign hit_win = (addr_i == P_WIN);

    always_comb begin
        req_o.op   = OP_IDLE;
        req_o.data = wdata_i;
        if (wr_i) begin
            if (hit_ptr)      req_o.op = OP_PTR_WR;
            else if (hit_win) req_o.op = OP_WIN_WR;
        end else if (rd_i) begin
            if (hit_ptr)      req_o.op = OP_PTR_RD;
            else if (hit_win) req_o.op = OP_WIN_RD;
        end
    end

endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              guard_wr_i,
    input  logic [DATA_W-1:0] guard_data_i,
    output logic              open_o
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (guard_wr_i) begin
            if (guard_data_i == OPEN_KEY)       open_q <= 1'b1;
            else if (guard_data_i == CLOSE_KEY) open_q <= 1'b0;
        end
    end

    assign open_o = open_q;

    // R5
    open_key_chk: assert property (@(posedge clk) disable iff (rst)
        guard_wr_i && guard_data_i == OPEN_KEY |=> open_o);

    // R6
    close_key_chk: assert property (@(posedge clk) disable iff (rst)
        guard_wr_i && guard_data_i == CLOSE_KEY |=> !open_o);

    // R6
    other_key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        guard_wr_i && guard_data_i != OPEN_KEY && guard_data_i != CLOSE_KEY
        |=> $stable(open_o));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_port_pkg::*;
#(
    parameter int N = NREGS,
    parameter logic [DATA_W-1:0] INIT = RESET_VAL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] cells [N];

    for (genvar g = 0; g < N; g++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= INIT;
            else if (wr_en_i && idx_i == DATA_W'(g))
                q <= wdata_i;
        end
        assign cells[g] = q;
    end

    assign rdata_o = cells[idx_i];

    // R4
    locked_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !open_i |-> !wr_en_i);

    // R9
    swi_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i && idx_i == SWI_IDX |-> !wdata_i[SWI_BIT]);

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    output logic              swi_req
);
    bus_req_t          req;
    logic [DATA_W-1:0] ptr_q;
    logic              open;
    logic              guard_wr;
    logic              bank_wr;
    logic [DATA_W-1:0] bank_wdata;
    logic [DATA_W-1:0] bank_rdata;
    logic              swi_q;

    cfg_bus_decode u_dec (
        .addr_i  (io_addr),
        .wdata_i (io_wdata),
        .wr_i    (io_wr),
        .rd_i    (io_rd),
        .req_o   (req)
    );

    always_ff @(posedge clk) begin
        if (rst)                   ptr_q <= '0;
        else if (req.op == OP_PTR_WR) ptr_q <= req.data;
    end

    assign guard_wr   = (req.op == OP_WIN_WR) && (ptr_q == GUARD_IDX);
    assign bank_wr    = (req.op == OP_WIN_WR) && (ptr_q != GUARD_IDX) && open;
    assign bank_wdata = stored_value(ptr_q, req.data);

    cfg_lock_ctrl u_lock (
        .clk          (clk),
        .rst          (rst),
        .guard_wr_i   (guard_wr),
        .guard_data_i (req.data),
        .open_o       (open)
    );

    cfg_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .open_i  (open),
        .wr_en_i (bank_wr),
        .idx_i   (ptr_q),
        .wdata_i (bank_wdata),
        .rdata_o (bank_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) swi_q <= 1'b0;
        else     swi_q <= bank_wr && is_swi_fire(ptr_q, req.data);
    end

    assign swi_req = swi_q;

    always_comb begin
        unique case (req.op)
            OP_PTR_RD: io_rdata = ptr_q;
            OP_WIN_RD: io_rdata = (ptr_q == GUARD_IDX) ? {{(DATA_W-1){1'b0}}, open}
                                                       : bank_rdata;
            default:   io_rdata = '0;
        endcase
    end

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        io_wr && io_addr == PTR_PORT |=> ptr_q == $past(io_wdata));

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == PTR_PORT) |=> $stable(ptr_q));

    // R9
    swi_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        swi_req |=> !swi_req);

    // R9
    swi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(swi_req) |-> $past(open && io_wr && io_addr == WIN_PORT
                                 && ptr_q == SWI_IDX && io_wdata[SWI_BIT]));

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == 8'h00);

endmodule

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        swi_req;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_mem [256];
    logic       m_open;
    logic [7:0] m_ptr;
    logic       pulse_seen;
    logic       pulse_after;

    always #10 clk = ~clk;   // 50 MHz

    cfg_index_port dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .swi_req(swi_req)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_win();
        if (m_ptr == 8'h13) return {7'b0, m_open};
        return m_mem[m_ptr];
    endfunction

    function automatic logic exp_pulse(input logic [15:0] a, input logic [7:0] d);
        return (a == 16'h0023) && m_open && (m_ptr == 8'h56) && d[6];
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a == 16'h0022) m_ptr = d;
        else if (a == 16'h0023) begin
            if (m_ptr == 8'h13) begin
                if (d == 8'hC5) m_open = 1'b1;
                else if (d == 8'h00) m_open = 1'b0;
            end else if (m_open) begin
                m_mem[m_ptr] = (m_ptr == 8'h56) ? (d & 8'hBF) : d;
            end
        end
    endtask

    // Performs a bus write, records swi_req in the cycle after and the one after that
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(posedge clk); #1;
        pulse_seen = swi_req;
        @(negedge clk);
        io_wr = 1'b0; io_addr = 16'hFFFF;
        @(posedge clk); #1;
        pulse_after = swi_req;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #2;
        v = io_rdata;
        @(negedge clk);
        io_rd = 1'b0; io_addr = 16'hFFFF;
    endtask

    task automatic chk_win(input string tag);
        logic [7:0] v;
        bus_read(16'h0023, v);
        check(v == exp_win(), tag, v, exp_win());
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        bus_write(16'h0022, idx);
        bus_write(16'h0023, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20241));
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        m_open = 1'b0; m_ptr = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check(swi_req == 1'b0, "R1 swi after reset", {7'b0, swi_req}, 8'h00);
        bus_read(16'h0022, v);
        check(v == 8'h00, "R1 pointer reset", v, 8'h00);
        chk_win("R1 reg00 reset");
        bus_write(16'h0022, 8'h13);
        chk_win("R1 R7 locked after reset");

        // R4 locked writes ignored
        wr_reg(8'h10, 8'hAA);
        chk_win("R4 locked write ignored");
        wr_reg(8'h56, 8'h40);
        check(pulse_seen == 1'b0, "R4 no swi while locked", {7'b0, pulse_seen}, 8'h00);
        chk_win("R4 reg56 unchanged");

        // R6 stray guard values keep lock
        wr_reg(8'h13, 8'h7E);
        chk_win("R6 stray value keeps locked");

        // R5 unlock and write several pairs
        wr_reg(8'h13, 8'hC5);
        chk_win("R5 R7 unlocked reads 01");
        wr_reg(8'h12, 8'h55);
        chk_win("R5 write reg12");
        wr_reg(8'h34, 8'hA3);
        chk_win("R5 write reg34");
        wr_reg(8'h13, 8'h3C);
        chk_win("R6 stray value keeps unlocked");

        // R8 pointer persists
        bus_write(16'h0022, 8'h12);
        chk_win("R8 repeat read 1");
        chk_win("R8 repeat read 2");
        bus_write(16'h0023, 8'h66);
        bus_write(16'h0023, 8'h67);
        chk_win("R8 repeat write same reg");
        bus_read(16'h0022, v);
        check(v == 8'h12, "R2 R8 pointer read back", v, 8'h12);

        // R9 software interrupt
        wr_reg(8'h56, 8'hFF);
        check(pulse_seen == 1'b1, "R9 swi pulse", {7'b0, pulse_seen}, 8'h01);
        check(pulse_after == 1'b0, "R9 swi one cycle", {7'b0, pulse_after}, 8'h00);
        chk_win("R9 bit6 reads zero");
        bus_write(16'h0023, 8'h21);
        check(pulse_seen == 1'b0, "R9 no swi bit6 clear", {7'b0, pulse_seen}, 8'h00);
        chk_win("R9 other bits stored");

        // R10 stray addresses
        bus_write(16'h0122, 8'h44);
        bus_write(16'h0024, 8'h99);
        bus_read(16'h0022, v);
        check(v == 8'h56, "R10 stray write kept pointer", v, 8'h56);
        chk_win("R10 stray write kept data");
        bus_read(16'h0123, v);
        check(v == 8'h00, "R10 stray read zero", v, 8'h00);

        // R6 relock, R4 again
        wr_reg(8'h13, 8'h00);
        chk_win("R6 R7 relocked");
        wr_reg(8'h56, 8'h40);
        check(pulse_seen == 1'b0, "R4 R9 no swi after relock", {7'b0, pulse_seen}, 8'h00);
        wr_reg(8'h12, 8'h01);
        chk_win("R4 write after relock ignored");

        // Random phase against the model
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [7:0] d;
            sel = $urandom_range(0, 9);
            d = 8'($urandom);
            case (sel)
                0: bus_write(16'h0022, 8'h13);
                1: bus_write(16'h0022, 8'h56);
                2, 3: bus_write(16'h0022, 8'($urandom_range(0, 15)) + 8'h10);
                4: begin
                    logic ep;
                    logic [7:0] dv;
                    dv = ($urandom_range(0, 1) != 0) ? 8'hC5 : 8'h00;
                    if (m_ptr != 8'h13) dv = d;
                    ep = exp_pulse(16'h0023, dv);
                    bus_write(16'h0023, dv);
                    check(pulse_seen == ep, "R5 R6 R9 random swi", {7'b0, pulse_seen}, {7'b0, ep});
                end
                5, 6: begin
                    logic ep;
                    ep = exp_pulse(16'h0023, d);
                    bus_write(16'h0023, d);
                    check(pulse_seen == ep && !pulse_after, "R4 R9 random swi",
                          {7'b0, pulse_seen}, {7'b0, ep});
                end
                7: bus_write(16'($urandom_range(0, 65535)) | 16'h0100, d);
                default: chk_win("R3 random read");
            endcase
        end
        bus_read(16'h0022, v);
        check(v == m_ptr, "R2 final pointer", v, m_ptr);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule